// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock waveform for an I2C master from the system clock. A programmable prescaler divides the input clock by `psc + 1` to form a slower module clock. Each SCL phase then lasts a programmed count of module clocks plus a built-in extension. The extension is 7 when the prescaler setting is zero, 6 when it is one, and 5 for any larger setting. The low and high phases have their own counts, so the duty cycle can be trimmed. The prescaler is normally chosen so that the module clock lands between 7 and 12 MHz.

The timing settings are sampled only while the block is disabled. When enable rises, SCL drops at once and the low phase runs first. The high phase follows, and the pair repeats. A one-cycle strobe marks every falling and every rising SCL edge, so that a bit sequencer can step its data in lock with the clock. When enable is dropped, SCL is released high and every counter is cleared.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and on the clock edge after enable is sampled low, `scl_o` is 1 and `fall_o` and `rise_o` are 0.
- R2: On the first clock edge where enable is sampled high after being low, `scl_o` goes to 0 and `fall_o` pulses for one cycle; the low phase is always the first phase.
- R3: The low phase lasts (low_cnt + d) × (psc + 1) input clock cycles, counted from the `fall_o` cycle to the `rise_o` cycle.
- R4: The high phase lasts (high_cnt + d) × (psc + 1) input clock cycles, counted from the `rise_o` cycle to the next `fall_o` cycle.
- R5: The extension d is 7 when psc = 0.
- R6: The extension d is 6 when psc = 1.
- R7: The extension d is 5 when psc is 2 or more.
- R8: Changes to `psc_i`, `low_cnt_i` or `high_cnt_i` while enabled have no effect on the waveform. The values present while disabled take effect at the next enable.
- R9: `fall_o` is 1 only in a cycle where `scl_o` is 0, and `rise_o` only in a cycle where `scl_o` is 1. The two strobes are never high together, and `scl_o` never falls without `fall_o`.
- R10: Dropping enable in the middle of a phase returns `scl_o` high without a `rise_o` strobe. A later enable starts a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low holds the block idle and loads the settings |
| psc_i | input | PSC_W | Prescaler setting; module clock = input clock / (psc + 1) |
| low_cnt_i | input | CNT_W | Low-phase count in module clocks, before the extension |
| high_cnt_i | input | CNT_W | High-phase count in module clocks, before the extension |
| scl_o | output | 1 | SCL level |
| fall_o | output | 1 | One-cycle strobe at each falling SCL edge |
| rise_o | output | 1 | One-cycle strobe at each rising SCL edge |

## Verification
Two situations are the hardest to reach from the ports: a settings change that must be ignored, and an abort part-way through a phase.

For the first, the bench enables the block with one setting and then drives very different values onto all three setting inputs. It measures the next full low and high phase and requires the old lengths. It then cycles enable and requires the new lengths.

For the abort, enable is dropped a few cycles into a low phase. The bench requires SCL to come back high with no rise strobe, and requires the next enable to produce a complete low phase rather than its remainder.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  // per-phase extension in module clocks, chosen by prescaler setting
  function automatic logic [2:0] phase_offset(input int unsigned psc);
    if (psc == 0) return 3'd7;
    else if (psc == 1) return 3'd6;
    else return 3'd5;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (wrap)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o
);
  import scl_timing_pkg::*;

  localparam int LEN_W = CNT_W + 1;

  logic [PSC_W-1:0] psc_q;
  logic [LEN_W-1:0] low_len_q, high_len_q, cur_len;
  logic [LEN_W-1:0] off_ext;
  logic             run_q, scl_q, fall_q, rise_q;
  logic             start, tick, done, restart;

  assign off_ext = LEN_W'(phase_offset(int'(psc_i)));
  assign start   = en_i && !run_q;
  assign restart = start || done;
  assign cur_len = scl_q ? high_len_q : low_len_q;

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .run_i(run_q), .restart_i(restart),
    .div_i(psc_q), .tick_o(tick)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_phase (
    .clk_i, .rst_ni, .run_i(run_q), .restart_i(restart),
    .tick_i(tick), .len_i(cur_len), .done_o(done)
  );

  // settings shadowed only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q      <= '0;
      low_len_q  <= LEN_W'(7);
      high_len_q <= LEN_W'(7);
    end else if (!en_i) begin
      psc_q      <= psc_i;
      low_len_q  <= LEN_W'(low_cnt_i) + off_ext;
      high_len_q <= LEN_W'(high_cnt_i) + off_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; scl_q <= 1'b1; fall_q <= 1'b0; rise_q <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0; scl_q <= 1'b1; fall_q <= 1'b0; rise_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1; scl_q <= 1'b0; fall_q <= 1'b1; rise_q <= 1'b0;
    end else begin
      fall_q <= done && scl_q;
      rise_q <= done && !scl_q;
      if (done) scl_q <= ~scl_q;
    end
  end

  assign scl_o  = scl_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_o,
  input logic fall_o,
  input logic rise_o
);
  // R1
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !fall_o && !rise_o));
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$past(en_i)) |=> (fall_o && !scl_o));
  // R9
  fall_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !scl_o);
  // R9
  rise_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> scl_o);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o}));
  // R9
  fall_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> fall_o);
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .scl_o(scl_o), .fall_o(fall_o), .rise_o(rise_o)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] psc_i = '0, low_cnt_i = '0, high_cnt_i = '0;
  logic       scl_o, fall_o, rise_o;
  int         n_chk = 0, n_fail = 0;
  bit         done_flag = 0;

  always #4 clk_i = ~clk_i;

  scl_timing_gen u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic program_cfg(input int p, input int lo, input int hi);
    @(negedge clk_i);
    en_i = 1'b0; psc_i = 8'(p); low_cnt_i = 8'(lo); high_cnt_i = 8'(hi);
    repeat (2) @(negedge clk_i);
  endtask

  // counts negedge samples until the selected strobe is seen
  task automatic wait_strobe(input bit want_rise, output int n);
    n = 0;
    do begin
      @(negedge clk_i); n++;
    end while (!(want_rise ? rise_o : fall_o) && n < 5000);
  endtask

  task automatic measure(output int lo, output int hi);
    int dummy;
    wait_strobe(1'b0, dummy);
    wait_strobe(1'b1, lo);
    wait_strobe(1'b0, hi);
  endtask

  task automatic run_case(input int p, input int lo, input int hi, input int d, input string dtag);
    int ml, mh, el, eh;
    program_cfg(p, lo, hi);
    en_i = 1'b1;
    @(negedge clk_i);
    check(fall_o && !scl_o, "R2 first fall", fall_o, 1);
    measure(ml, mh);
    el = (lo + d) * (p + 1); eh = (hi + d) * (p + 1);
    check(ml == el, {"R3 low len ", dtag}, ml, el);
    check(mh == eh, {"R4 high len ", dtag}, mh, eh);
  endtask

  task automatic test_reset();
    check(scl_o === 1'b1, "R1 reset scl", scl_o, 1);
    check(fall_o === 1'b0 && rise_o === 1'b0, "R1 reset strobes", fall_o | rise_o, 0);
  endtask

  task automatic test_ignore_change();
    int ml, mh;
    program_cfg(0, 3, 2);
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    psc_i = 8'd3; low_cnt_i = 8'd0; high_cnt_i = 8'd1;
    measure(ml, mh);
    check(ml == 10, "R8 low unchanged", ml, 10);
    check(mh == 9, "R8 high unchanged", mh, 9);
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    measure(ml, mh);
    check(ml == 20, "R8 new low", ml, 20);
    check(mh == 24, "R8 new high", mh, 24);
  endtask

  task automatic test_abort();
    int ml, mh, seen_rise;
    program_cfg(1, 4, 6);
    en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check(scl_o == 1'b0, "R10 mid low", scl_o, 0);
    en_i = 1'b0;
    seen_rise = 0;
    repeat (3) begin
      @(negedge clk_i);
      if (rise_o) seen_rise++;
    end
    check(scl_o == 1'b1, "R10 released", scl_o, 1);
    check(seen_rise == 0, "R10 no rise strobe", seen_rise, 0);
    check(!fall_o && !rise_o, "R1 idle strobes", fall_o | rise_o, 0);
    en_i = 1'b1;
    @(negedge clk_i);
    check(fall_o == 1'b1, "R10 restart fall", fall_o, 1);
    wait_strobe(1'b1, ml);
    check(ml == 20, "R10 full low", ml, 20);
    wait_strobe(1'b0, mh);
    check(mh == 24, "R4 high after restart", mh, 24);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    run_case(0, 3, 2, 7, "R5 d7");
    run_case(1, 4, 6, 6, "R6 d6");
    run_case(2, 1, 0, 5, "R7 d5 psc2");
    run_case(5, 2, 3, 5, "R7 d5 psc5");
    test_ignore_change();
    test_abort();
    done_flag = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 150000) begin
      @(posedge clk_i); cyc++;
    end
    if (!done_flag) check(1'b0, "watchdog", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule